// File: doc/BRIEF.md
# Interrupt Line Dispatcher with End-of-Interrupt Gating

This block watches a bank of interrupt input lines, each governed by a routing entry word. The entry word holds a vector, a delivery mode, a destination mode, a trigger mode, a mask bit and an 8-bit destination. The block keeps one pending bit per line. It decides when a line should produce an interrupt message and presents that message downstream on a valid/ready handshake, one message at a time. Level-triggered lines carry an in-service flag. While the flag is set, the line cannot deliver again. An end-of-interrupt broadcast that names the line's vector clears the flag. The block reports the in-service flag and a delivery-busy flag for every line, so the routing table can show them to software.

Routing entries arrive on a flat port. Each line holds one 32-bit word, plus an 8-bit destination word. Any change to a line's word causes that line to be evaluated again. For example, unmasking a line whose pending bit is still set releases its held request. When several lines wait for evaluation, the lowest-numbered line goes first. Requests for evaluation stay queued per line while the output is stalled.

Top module: `irq_dispatch`

## Requirements
- R1: A line asserts only on a low-to-high transition of its input. Holding the input high yields exactly one message per rising edge.
- R2: A rising edge on a line whose entry word has bit 15 = 0 (edge) and bit 16 = 1 (masked) is discarded. Unmasking that line later sends no message.
- R3: A pending line whose mask bit 16 is set stays pending without sending. Clearing the mask later sends its message.
- R4: On delivery from an edge line (bit 15 = 0), the pending bit clears. A later re-evaluation of that line sends nothing until a new rising edge.
- R5: On delivery from a level line (bit 15 = 1), the line's in-service flag (`remote_irr_o`) sets. While that flag is set, re-evaluating the line sends no message.
- R6: An end-of-interrupt whose vector equals a line's entry bits 7:0 clears that line's in-service flag and re-evaluates the line. A line still asserted then sends again. A non-matching vector changes nothing.
- R7: A falling edge on a level line clears its pending bit. Unmasking the line afterwards sends nothing.
- R8: Only delivery modes 0 and 1 (entry bits 10:8) produce a message. Any other mode completes the evaluation silently.
- R9: The message carries vector = entry bits 7:0, delivery mode = bits 10:8, logical-destination flag = bit 11, level flag = bit 15, and destination = the line's 8-bit destination word.
- R10: `deliv_status_o` for a line rises in the cycle after an accepted assertion. It falls on the following cycle, when the idle dispatcher evaluates that line.
- R11: When several lines are ready for evaluation together, the lowest-numbered line is sent first.
- R12: A message stays stable on the output until `msg_ready_i` accepts it. Pending and in-service state change only at acceptance, and `msg_valid_o` drops in the cycle after acceptance.
- R13: A change to any of a line's entry bits 16, 15, 11:8 or 7:0 queues that line for re-evaluation.
- R14: After reset, no message is valid and all in-service and delivery-busy flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_LINES | Interrupt input lines |
| entry_i | input | 32*N_LINES | Routing entry word per line (line i at bits 32i+31:32i) |
| dest_i | input | 8*N_LINES | Destination per line |
| eoi_valid_i | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector_i | input | 8 | Vector named by the end-of-interrupt |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Downstream accepts message |
| msg_vector_o | output | 8 | Message vector |
| msg_dmode_o | output | 3 | Message delivery mode |
| msg_logical_o | output | 1 | Logical destination mode |
| msg_level_o | output | 1 | Level-triggered source |
| msg_dest_o | output | 8 | Message destination |
| remote_irr_o | output | N_LINES | In-service flag per line |
| deliv_status_o | output | N_LINES | Delivery-busy flag per line |

## Verification
A table of edge lines covers every delivery mode class: fixed, lowest priority, a non-sending mode, a masked line and a logical destination. This separates the mode filter from the field mapping. A held-high input separates edge sensing from level sensing. On level lines, the bench runs a masked assert followed by an unmask, then a second trigger, then a wrong-vector end-of-interrupt, then a matching one. This shows that the in-service flag, and not the pending bit, blocks delivery. Two lines raised together under a stalled output check the priority order and that the held message stays stable. A level line stalled at the output shows that the in-service flag waits for acceptance.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int VEC_W   = 8;
  localparam int DM_W    = 3;
  localparam int DEST_W  = 8;
  localparam int WORD_W  = 32;
  // positions inside a routing entry word
  localparam int POS_VEC   = 0;
  localparam int POS_DM    = 8;
  localparam int POS_LOGIC = 11;
  localparam int POS_LEVEL = 15;
  localparam int POS_MASK  = 16;

  localparam logic [DM_W-1:0] DM_FIXED  = 3'd0;
  localparam logic [DM_W-1:0] DM_LOWEST = 3'd1;

  typedef struct packed {
    logic             mask;
    logic             level;
    logic             logical;
    logic [DM_W-1:0]  dmode;
    logic [VEC_W-1:0] vector;
  } entry_t;

  localparam entry_t ENTRY_RST = '{mask: 1'b1, level: 1'b0, logical: 1'b0,
                                   dmode: '0, vector: '0};

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [DM_W-1:0]   dmode;
    logic              logical;
    logic              level;
    logic [DEST_W-1:0] dest;
  } msg_t;

  function automatic entry_t decode_entry(input logic [WORD_W-1:0] w);
    entry_t e;
    e.vector  = w[POS_VEC +: VEC_W];
    e.dmode   = w[POS_DM +: DM_W];
    e.logical = w[POS_LOGIC];
    e.level   = w[POS_LEVEL];
    e.mask    = w[POS_MASK];
    return e;
  endfunction

  function automatic logic mode_sends(input logic [DM_W-1:0] m);
    return (m == DM_FIXED) || (m == DM_LOWEST);
  endfunction
endpackage

// File: rtl/irq_edge_sense.sv
module irq_edge_sense #(
  parameter int N_LINES = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] rise_o,
  output logic [N_LINES-1:0] fall_o
);
  logic [N_LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= line_i;
  end

  always_comb begin
    rise_o = line_i & ~prev_q;
    fall_o = ~line_i & prev_q;
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N_LINES = 24,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] req_i,
  input  logic               en_i,
  output logic [N_LINES-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (req_i[i] && en_i) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        idx_o   = IDX_W'(i);
        any_o   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_line_state.sv
module irq_line_state
  import irq_dispatch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  input  entry_t           entry_i,
  input  logic             eoi_valid_i,
  input  logic [VEC_W-1:0] eoi_vector_i,
  input  logic             sel_i,
  input  logic             clr_pend_i,
  input  logic             set_remote_i,
  output logic             pending_o,
  output logic             remote_o,
  output logic             status_o,
  output logic             eval_o
);
  logic   pend_q, pend_d;
  logic   rem_q, rem_d;
  logic   stat_q, stat_d;
  logic   eval_q, eval_d;
  entry_t entry_q;
  logic   take_edge, eoi_hit, entry_chg;

  always_comb begin
    // edge-mode masked assertions are discarded outright
    take_edge = rise_i && !(entry_i.mask && !entry_i.level);
    eoi_hit   = eoi_valid_i && (eoi_vector_i == entry_i.vector) && rem_q;
    entry_chg = (entry_i != entry_q);

    pend_d = pend_q;
    if (take_edge)                                 pend_d = 1'b1;
    else if (clr_pend_i || (fall_i && entry_i.level)) pend_d = 1'b0;

    rem_d = rem_q;
    if (set_remote_i) rem_d = 1'b1;
    else if (eoi_hit) rem_d = 1'b0;

    eval_d = eval_q;
    if (take_edge || eoi_hit || entry_chg) eval_d = 1'b1;
    else if (sel_i)                        eval_d = 1'b0;

    stat_d = stat_q;
    if (take_edge)  stat_d = 1'b1;
    else if (sel_i) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rem_q  <= 1'b0;
      stat_q <= 1'b0;
      eval_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      rem_q  <= rem_d;
      stat_q <= stat_d;
      eval_q <= eval_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         entry_q <= ENTRY_RST;
    else if (entry_chg) entry_q <= entry_i;
  end

  assign pending_o = pend_q;
  assign remote_o  = rem_q;
  assign status_o  = stat_q;
  assign eval_o    = eval_q;
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int N_LINES = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LINES-1:0]        irq_i,
  input  logic [N_LINES*WORD_W-1:0] entry_i,
  input  logic [N_LINES*DEST_W-1:0] dest_i,
  input  logic                      eoi_valid_i,
  input  logic [VEC_W-1:0]          eoi_vector_i,
  output logic                      msg_valid_o,
  input  logic                      msg_ready_i,
  output logic [VEC_W-1:0]          msg_vector_o,
  output logic [DM_W-1:0]           msg_dmode_o,
  output logic                      msg_logical_o,
  output logic                      msg_level_o,
  output logic [DEST_W-1:0]         msg_dest_o,
  output logic [N_LINES-1:0]        remote_irr_o,
  output logic [N_LINES-1:0]        deliv_status_o
);
  localparam int IDX_W = $clog2(N_LINES);

  entry_t             ent [N_LINES];
  logic [DEST_W-1:0]  dst [N_LINES];
  logic [N_LINES-1:0] rise, fall, pend, remote, status, eval;
  logic [N_LINES-1:0] grant, clr_pend, set_remote;
  logic [N_LINES-1:0] unused_ro_bits;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_any;

  logic               out_valid_q, out_valid_d;
  msg_t               out_msg_q, out_msg_d;
  logic [IDX_W-1:0]   out_line_q;
  logic               load, imm_clr, imm_rem, accept;
  entry_t             s_ent;
  logic               s_go;

  irq_edge_sense #(.N_LINES(N_LINES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (irq_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  irq_lowest_pick #(.N_LINES(N_LINES)) u_pick (
    .req_i   (eval),
    .en_i    (!out_valid_q),
    .grant_o (grant),
    .idx_o   (pick_idx),
    .any_o   (pick_any)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign ent[g] = decode_entry(entry_i[g*WORD_W +: WORD_W]);
    assign dst[g] = dest_i[g*DEST_W +: DEST_W];
    // read-only and reserved entry bits take no part in dispatch
    assign unused_ro_bits[g] = ^{entry_i[g*WORD_W+12 +: 3], entry_i[g*WORD_W+17 +: 15]};

    irq_line_state u_state (
      .clk          (clk),
      .rst_n        (rst_n),
      .rise_i       (rise[g]),
      .fall_i       (fall[g]),
      .entry_i      (ent[g]),
      .eoi_valid_i  (eoi_valid_i),
      .eoi_vector_i (eoi_vector_i),
      .sel_i        (grant[g]),
      .clr_pend_i   (clr_pend[g]),
      .set_remote_i (set_remote[g]),
      .pending_o    (pend[g]),
      .remote_o     (remote[g]),
      .status_o     (status[g]),
      .eval_o       (eval[g])
    );
  end

  // evaluation of the granted line
  always_comb begin
    s_ent   = ent[pick_idx];
    s_go    = pick_any && pend[pick_idx] && !s_ent.mask;
    load    = s_go && mode_sends(s_ent.dmode) && (!s_ent.level || !remote[pick_idx]);
    imm_clr = s_go && !s_ent.level && !mode_sends(s_ent.dmode);
    imm_rem = s_go && s_ent.level && !remote[pick_idx] && !mode_sends(s_ent.dmode);
    accept  = out_valid_q && msg_ready_i;
  end

  // state updates: immediate for silent outcomes, at handshake for messages
  always_comb begin
    clr_pend   = '0;
    set_remote = '0;
    if (imm_clr) clr_pend   = grant;
    if (imm_rem) set_remote = grant;
    if (accept) begin
      if (out_msg_q.level) set_remote[out_line_q] = 1'b1;
      else                 clr_pend[out_line_q]   = 1'b1;
    end
  end

  always_comb begin
    out_valid_d = out_valid_q;
    if (load)        out_valid_d = 1'b1;
    else if (accept) out_valid_d = 1'b0;
    out_msg_d.vector  = s_ent.vector;
    out_msg_d.dmode   = s_ent.dmode;
    out_msg_d.logical = s_ent.logical;
    out_msg_d.level   = s_ent.level;
    out_msg_d.dest    = dst[pick_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid_q <= 1'b0;
    else        out_valid_q <= out_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_msg_q  <= '0;
      out_line_q <= '0;
    end else if (load) begin
      out_msg_q  <= out_msg_d;
      out_line_q <= pick_idx;
    end
  end

  assign msg_valid_o    = out_valid_q;
  assign msg_vector_o   = out_msg_q.vector;
  assign msg_dmode_o    = out_msg_q.dmode;
  assign msg_logical_o  = out_msg_q.logical;
  assign msg_level_o    = out_msg_q.level;
  assign msg_dest_o     = out_msg_q.dest;
  assign remote_irr_o   = remote;
  assign deliv_status_o = status;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import irq_dispatch_pkg::*;
#(
  parameter int N_LINES = 24
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_LINES*WORD_W-1:0] entry_i,
  input logic                      eoi_valid_i,
  input logic [VEC_W-1:0]          eoi_vector_i,
  input logic                      msg_valid_o,
  input logic                      msg_ready_i,
  input logic [VEC_W-1:0]          msg_vector_o,
  input logic [DM_W-1:0]           msg_dmode_o,
  input logic                      msg_level_o,
  input logic [DEST_W-1:0]         msg_dest_o,
  input logic [N_LINES-1:0]        remote_irr_o
);
  logic unused_chk;
  assign unused_chk = ^entry_i;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_vector_o)
      && $stable(msg_dmode_o) && $stable(msg_dest_o)); // R12

  AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && msg_ready_i |=> !msg_valid_o); // R12

  AST_MODE_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> (msg_dmode_o[2:1] == 2'b00)); // R8

  AST_LEVEL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && msg_ready_i && msg_level_o |=> (remote_irr_o != '0)); // R5

  for (genvar g = 0; g < N_LINES; g++) begin : g_eoi
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_valid_i && (eoi_vector_i == entry_i[g*WORD_W +: VEC_W]) && remote_irr_o[g]
        && !(msg_valid_o && msg_ready_i) |=> !remote_irr_o[g]); // R6
  end
endmodule

bind irq_dispatch irq_dispatch_chk #(.N_LINES(N_LINES)) u_chk (.*);

// File: tb/test_irq_dispatch.sv
`timescale 1ns/100ps
module test_irq_dispatch;
  localparam int N = 24;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    irq;
  logic [N*32-1:0] entry_flat;
  logic [N*8-1:0]  dest_flat;
  logic            eoi_v;
  logic [7:0]      eoi_vec;
  logic            msg_valid, msg_ready, msg_logical, msg_level;
  logic [7:0]      msg_vector, msg_dest;
  logic [2:0]      msg_dmode;
  logic [N-1:0]    remote, status;

  logic [31:0] ent [N];
  logic [7:0]  dst [N];

  int n_chk = 0;
  int n_fail = 0;
  int rc = 0;
  logic [7:0] r_vec [64];
  logic [2:0] r_dm  [64];
  logic       r_log [64];
  logic       r_lvl [64];
  logic [7:0] r_dst [64];

  irq_dispatch #(.N_LINES(N)) i_irq_dispatch (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .entry_i(entry_flat), .dest_i(dest_flat),
    .eoi_valid_i(eoi_v), .eoi_vector_i(eoi_vec), .msg_valid_o(msg_valid),
    .msg_ready_i(msg_ready), .msg_vector_o(msg_vector), .msg_dmode_o(msg_dmode),
    .msg_logical_o(msg_logical), .msg_level_o(msg_level), .msg_dest_o(msg_dest),
    .remote_irr_o(remote), .deliv_status_o(status));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      entry_flat[i*32 +: 32] = ent[i];
      dest_flat[i*8 +: 8]    = dst[i];
    end
  end

  // record every accepted message
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      r_vec[rc[5:0]] = msg_vector;
      r_dm[rc[5:0]]  = msg_dmode;
      r_log[rc[5:0]] = msg_logical;
      r_lvl[rc[5:0]] = msg_level;
      r_dst[rc[5:0]] = msg_dest;
      rc = rc + 1;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_v = 1'b1; eoi_vec = v;
    step(1);
    eoi_v = 1'b0;
  endtask

  typedef struct packed {
    logic [4:0]  line;
    logic [31:0] word;
    logic [7:0]  d;
    logic        exp;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{5'd2,  32'h0000_0031, 8'h01, 1'b1},   // fixed, physical
    '{5'd7,  32'h0000_0942, 8'h0A, 1'b1},   // lowest priority, logical
    '{5'd9,  32'h0000_0455, 8'h02, 1'b0},   // mode 4: silent
    '{5'd11, 32'h0001_0066, 8'h03, 1'b0},   // masked edge: dropped
    '{5'd23, 32'h0000_01F0, 8'hFF, 1'b1},   // top line, lowest priority
    '{5'd0,  32'h0000_0220, 8'h04, 1'b0}    // mode 2: silent
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int base;
    rst_n = 1'b0; irq = '0; eoi_v = 1'b0; eoi_vec = '0; msg_ready = 1'b1;
    for (int i = 0; i < N; i++) begin ent[i] = 32'h0001_0000; dst[i] = 8'h00; end
    step(4);
    rst_n = 1'b1;
    step(2);
    // R14 reset state
    chk("R14 valid", msg_valid, 0);
    chk("R14 remote", remote, 0);
    chk("R14 status", status, 0);

    // table walk: R8 mode filter, R2 masked drop, R9 field mapping
    for (int k = 0; k < 6; k++) begin
      base = rc;
      ent[ROWS[k].line] = ROWS[k].word;
      dst[ROWS[k].line] = ROWS[k].d;
      step(3);
      irq[ROWS[k].line] = 1'b1;
      step(2);
      irq[ROWS[k].line] = 1'b0;
      step(8);
      chk("R8 message count", rc - base, ROWS[k].exp);
      if (ROWS[k].exp) begin
        chk("R9 vector", r_vec[base[5:0]], ROWS[k].word[7:0]);
        chk("R9 dmode", r_dm[base[5:0]], ROWS[k].word[10:8]);
        chk("R9 logical", r_log[base[5:0]], ROWS[k].word[11]);
        chk("R9 level", r_lvl[base[5:0]], 0);
        chk("R9 dest", r_dst[base[5:0]], ROWS[k].d);
      end
    end

    // R1 held-high input gives one message per rising edge; R4 pending cleared
    base = rc;
    ent[3] = 32'h0000_0013;
    step(3);
    irq[3] = 1'b1;
    step(12);
    chk("R1 held high", rc - base, 1);
    ent[3] = 32'h0000_0113;   // R13 re-evaluation of an edge line: R4 nothing left
    step(8);
    chk("R4 no repeat", rc - base, 1);
    irq[3] = 1'b0;
    step(2);
    irq[3] = 1'b1;
    step(8);
    chk("R1 second edge", rc - base, 2);
    irq[3] = 1'b0;

    // R2 masked edge discarded, unmask sends nothing
    base = rc;
    ent[4] = 32'h0001_0014;
    step(3);
    irq[4] = 1'b1; step(2); irq[4] = 1'b0;
    step(4);
    ent[4] = 32'h0000_0014;
    step(8);
    chk("R2 dropped", rc - base, 0);

    // R3 / R13 masked level pending, unmask delivers; R5 in-service flag
    base = rc;
    ent[5] = 32'h0001_8025;
    step(3);
    irq[5] = 1'b1;
    step(6);
    chk("R3 held while masked", rc - base, 0);
    ent[5] = 32'h0000_8025;
    step(8);
    chk("R13 unmask delivers", rc - base, 1);
    chk("R9 level vector", r_vec[base[5:0]], 8'h25);
    chk("R9 level flag", r_lvl[base[5:0]], 1);
    chk("R5 flag set", remote[5], 1);
    ent[5] = 32'h0000_8125;
    step(8);
    chk("R5 blocked", rc - base, 1);
    eoi(8'h99);
    step(6);
    chk("R6 wrong vector count", rc - base, 1);
    chk("R6 wrong vector flag", remote[5], 1);
    eoi(8'h25);
    step(8);
    chk("R6 redeliver", rc - base, 2);
    chk("R6 flag again", remote[5], 1);
    irq[5] = 1'b0;
    step(2);
    eoi(8'h25);
    step(8);
    chk("R7 fall then eoi count", rc - base, 2);
    chk("R6 flag cleared", remote[5], 0);

    // R7 level fall clears pending
    base = rc;
    ent[6] = 32'h0001_8026;
    step(3);
    irq[6] = 1'b1; step(3); irq[6] = 1'b0;
    step(3);
    ent[6] = 32'h0000_8026;
    step(8);
    chk("R7 nothing sent", rc - base, 0);
    chk("R7 flag", remote[6], 0);

    // R10 delivery-busy timing
    base = rc;
    ent[8] = 32'h0001_8028;
    step(4);
    irq[8] = 1'b1;
    step(1);
    chk("R10 status set", status[8], 1);
    step(1);
    chk("R10 status cleared", status[8], 0);
    irq[8] = 1'b0;
    step(4);
    chk("R10 no message", rc - base, 0);

    // R11 priority, R12 stall stability
    base = rc;
    msg_ready = 1'b0;
    ent[10] = 32'h0000_003A;
    ent[12] = 32'h0000_003C;
    step(3);
    irq[10] = 1'b1; irq[12] = 1'b1;
    step(4);
    chk("R12 valid", msg_valid, 1);
    chk("R11 lowest first", msg_vector, 8'h3A);
    step(3);
    chk("R12 stable", msg_vector, 8'h3A);
    chk("R12 not taken", rc - base, 0);
    msg_ready = 1'b1;
    step(8);
    chk("R11 count", rc - base, 2);
    chk("R11 order first", r_vec[base[5:0]], 8'h3A);
    chk("R11 order second", r_vec[6'(base + 1)], 8'h3C);
    irq[10] = 1'b0; irq[12] = 1'b0;

    // R12 in-service flag waits for acceptance
    msg_ready = 1'b0;
    ent[13] = 32'h0000_804D;
    step(3);
    irq[13] = 1'b1;
    step(4);
    chk("R12 level valid", msg_valid, 1);
    chk("R12 flag before accept", remote[13], 0);
    msg_ready = 1'b1;
    step(3);
    chk("R12 flag after accept", remote[13], 1);
    irq[13] = 1'b0;
    step(1);
    eoi(8'h4D);
    step(3);
    chk("R6 eoi clears", remote[13], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule